// File: doc/BRIEF.md
# Overcurrent Constant-Current Limiter

This block sits between a digital overcurrent comparator and the gate-drive logic of a synchronous step-down converter. While the comparator flag is high, the block blocks the high-side switch and forces the low-side switch on, so the inductor current is limited one switching cycle at a time. A switching cycle runs from one `cycle_start` pulse to the next; each cycle counts as at most one overcurrent event. The limit stays in force while the flag stays high and, in any case, until the next cycle begins.

The block counts consecutive switching cycles that contain an overcurrent. A single clean cycle clears the count. When the count reaches `TRIP_COUNT` (7 by default), the block latches a fault: both switches are off, and a power-good pull-low request is raised. The latch clears only when `enable` is driven low or when `rst_n` (supply dropout) is asserted.

The control is a four-state machine. OFF is the disabled state. RUN is normal switching. LIMIT is constant-current mode. TRIP is the latched fault. The transitions are:
- ENABLE: OFF to RUN, when `enable` is high.
- LIMIT_ENTER: RUN to LIMIT, when the flag is sampled high.
- LIMIT_EXIT: LIMIT to RUN, at a `cycle_start` edge with the flag low.
- TRIP: RUN or LIMIT to TRIP, on the event that completes the count.
- DISABLE: any state to OFF, when `enable` is low.

Top module: `oc_limiter`

## Requirements
- R1: After reset and while in OFF, `hs_block`=1, `ls_force`=0, `fault_latched`=0 and `pgood_pull_low`=0, and `oc_flag` has no effect on any of them.
- R2: With `enable` high, OFF moves to RUN at the next clock edge. In RUN with `oc_flag`=0, `hs_block`=0 and `ls_force`=0.
- R3: In RUN, `oc_flag`=1 drives `hs_block`=1 and `ls_force`=1 in the same cycle, with no clock edge in between. `ls_force`=1 never occurs with `hs_block`=0.
- R4: Once `oc_flag` is sampled high, `hs_block`=1 and `ls_force`=1 hold through every edge until a `cycle_start` edge with `oc_flag`=0. A `cycle_start` edge with `oc_flag`=1 keeps the limit on.
- R5: Any number of `oc_flag` pulses within one switching cycle counts as one event.
- R6: A switching cycle with no overcurrent resets the consecutive-event count to zero.
- R7: At the edge that samples the first overcurrent of the `TRIP_COUNT`-th consecutive cycle, the block enters TRIP. There, `hs_block`=1, `ls_force`=0 and `fault_latched`=1.
- R8: `pgood_pull_low` equals `fault_latched` at all times.
- R9: TRIP persists while `enable` stays high, whatever `oc_flag` and `cycle_start` do. It clears to OFF one edge after `enable` goes low, and at once on `rst_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset (supply dropout) |
| enable | input | 1 | Converter enable; low disables and clears the fault |
| cycle_start | input | 1 | One-clock pulse marking the start of a switching cycle |
| oc_flag | input | 1 | Overcurrent comparator output, high when sensed current exceeds threshold |
| hs_block | output | 1 | Holds the high-side switch off |
| ls_force | output | 1 | Forces the low-side switch on |
| fault_latched | output | 1 | Latched overcurrent shutdown |
| pgood_pull_low | output | 1 | Request to pull the power-good line low |

## Verification
A wrong event count shows at the ports as a fault latch that comes one or more switching cycles early or late. A mis-counted multi-pulse cycle and a count not cleared by a clean cycle therefore both surface on `fault_latched` within a few cycles of the seventh event. A wrong state shows on `hs_block` and `ls_force` in the very cycle it occurs. For example, LIMIT released too early drops `ls_force` before the next `cycle_start`, and a leaky TRIP lets `oc_flag` reach `ls_force` while the fault is set.

// File: rtl/oc_lim_pkg.sv
package oc_lim_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_LIMIT = 2'd2,
        ST_TRIP  = 2'd3
    } lim_state_e;

endpackage

// File: rtl/oc_event_counter.sv
module oc_event_counter #(
    parameter int TRIP_COUNT = 7,
    localparam int CW = (TRIP_COUNT > 2) ? $clog2(TRIP_COUNT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    input  logic cycle_start,
    input  logic oc_flag,
    output logic trip_now
);

    logic [CW-1:0] cnt_q;
    logic          seen_q;
    logic [CW-1:0] cnt_base;
    logic          new_event;

    // A cycle boundary after a clean cycle restarts the run (R6)
    always_comb begin
        cnt_base  = (cycle_start && !seen_q) ? '0 : cnt_q;
        new_event = count_en && oc_flag && (cycle_start || !seen_q);
        trip_now  = new_event && (cnt_base == CW'(TRIP_COUNT - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (!count_en) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            seen_q <= cycle_start ? oc_flag : (seen_q || oc_flag);
            if (trip_now)
                cnt_q <= '0;
            else
                cnt_q <= cnt_base + CW'(new_event);
        end
    end

    // R5: count never reaches the trip value as stored state
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(TRIP_COUNT - 1) || cnt_q == CW'(TRIP_COUNT - 1));

    // R5: a second pulse inside the same cycle does not move the count
    p_single_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && seen_q && !cycle_start) |=> (cnt_q == $past(cnt_q)));

    // R6: a clean cycle followed by a quiet boundary zeroes the count
    p_gap_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && cycle_start && !seen_q && !oc_flag) |=> (cnt_q == '0));

endmodule

// File: rtl/oc_limit_fsm.sv
module oc_limit_fsm
    import oc_lim_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic cycle_start,
    input  logic oc_flag,
    input  logic trip_now,
    output logic count_en,
    output logic hs_block,
    output logic ls_force,
    output logic fault_latched,
    output logic pgood_pull_low
);

    lim_state_e state_q, state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (enable) state_d = ST_RUN;                          // ENABLE
            ST_RUN: begin
                if (!enable)       state_d = ST_OFF;                         // DISABLE
                else if (trip_now) state_d = ST_TRIP;                        // TRIP
                else if (oc_flag)  state_d = ST_LIMIT;                       // LIMIT_ENTER
            end
            ST_LIMIT: begin
                if (!enable)                       state_d = ST_OFF;         // DISABLE
                else if (trip_now)                 state_d = ST_TRIP;        // TRIP
                else if (cycle_start && !oc_flag)  state_d = ST_RUN;         // LIMIT_EXIT
            end
            ST_TRIP:  if (!enable) state_d = ST_OFF;                         // DISABLE
            default:  state_d = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        hs_block       = 1'b1;
        ls_force       = 1'b0;
        fault_latched  = 1'b0;
        pgood_pull_low = 1'b0;
        count_en       = 1'b0;
        unique case (state_q)
            ST_OFF: ;
            ST_RUN: begin
                hs_block = oc_flag;
                ls_force = oc_flag;
                count_en = 1'b1;
            end
            ST_LIMIT: begin
                ls_force = 1'b1;
                count_en = 1'b1;
            end
            ST_TRIP: begin
                fault_latched  = 1'b1;
                pgood_pull_low = 1'b1;
            end
            default: ;
        endcase
    end

    // R3: low-side force only ever with the high side blocked
    p_no_shoot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ls_force |-> hs_block);

    // R4: limit holds across edges until a quiet cycle boundary
    p_limit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LIMIT && enable && !cycle_start && !trip_now)
            |=> (state_q == ST_LIMIT && ls_force));

    // R7: completing the count latches the fault
    p_trip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_now && enable) |=> (fault_latched && !ls_force));

    // R8: power-good request follows the fault
    p_pg_tracks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pgood_pull_low == fault_latched);

    // R9: the fault is sticky while enabled and cleared when disabled
    p_fault_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_latched && enable) |=> fault_latched);
    p_fault_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !fault_latched);

endmodule

// File: rtl/oc_limiter.sv
module oc_limiter #(
    parameter int TRIP_COUNT = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic cycle_start,
    input  logic oc_flag,
    output logic hs_block,
    output logic ls_force,
    output logic fault_latched,
    output logic pgood_pull_low
);

    logic count_en;
    logic trip_now;

    oc_event_counter #(
        .TRIP_COUNT (TRIP_COUNT)
    ) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .count_en    (count_en),
        .cycle_start (cycle_start),
        .oc_flag     (oc_flag),
        .trip_now    (trip_now)
    );

    oc_limit_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .enable         (enable),
        .cycle_start    (cycle_start),
        .oc_flag        (oc_flag),
        .trip_now       (trip_now),
        .count_en       (count_en),
        .hs_block       (hs_block),
        .ls_force       (ls_force),
        .fault_latched  (fault_latched),
        .pgood_pull_low (pgood_pull_low)
    );

endmodule

// File: tb/oc_limiter_test.sv
module oc_limiter_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic cycle_start = 1'b0;
    logic oc_flag = 1'b0;
    logic hs_block, ls_force, fault_latched, pgood_pull_low;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    oc_limiter #(.TRIP_COUNT(7)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .enable         (enable),
        .cycle_start    (cycle_start),
        .oc_flag        (oc_flag),
        .hs_block       (hs_block),
        .ls_force       (ls_force),
        .fault_latched  (fault_latched),
        .pgood_pull_low (pgood_pull_low)
    );

    // {enable, cycle_start, oc_flag} {hs, ls, fault, pg} requirement number
    localparam logic [10:0] VECS [NVEC] = '{
        {3'b000, 4'b1000, 4'd1},  // R1 disabled
        {3'b001, 4'b1000, 4'd1},  // R1 flag ignored when off
        {3'b100, 4'b1000, 4'd2},  // R2 still off before edge
        {3'b110, 4'b0000, 4'd2},  // R2 running
        {3'b101, 4'b1100, 4'd3},  // R3 same-cycle limit
        {3'b100, 4'b1100, 4'd4},  // R4 held after flag drops
        {3'b110, 4'b1100, 4'd4},  // R4 held up to boundary
        {3'b100, 4'b0000, 4'd4},  // R4 released
        {3'b110, 4'b0000, 4'd6},  // R6 clean boundary
        {3'b111, 4'b1100, 4'd3},  // R3 flag at boundary
        {3'b111, 4'b1100, 4'd4},  // R4 flag persists over boundary
        {3'b100, 4'b1100, 4'd4},
        {3'b110, 4'b1100, 4'd4},
        {3'b000, 4'b0000, 4'd2},  // RUN until disable edge
        {3'b000, 4'b1000, 4'd1}   // R1 back to off
    };

    function automatic logic [3:0] outs();
        return {hs_block, ls_force, fault_latched, pgood_pull_low};
    endfunction

    task automatic check(input string req, input logic [3:0] exp);
        checks++;
        if (outs() !== exp) begin
            errors++;
            $display("FAIL %s: outputs {hs,ls,fault,pg} actual %b expected %b", req, outs(), exp);
        end
    endtask

    task automatic drive(input logic cs, input logic oc);
        cycle_start = cs;
        oc_flag     = oc;
    endtask

    // One switching cycle of three clocks; flag in first and/or third clock
    task automatic do_cycle(input logic pulse_a, input logic pulse_b);
        @(negedge clk) drive(1'b1, pulse_a);
        @(negedge clk) drive(1'b0, 1'b0);
        @(negedge clk) drive(1'b0, pulse_b);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                $display("FAIL watchdog: run did not finish");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        #1 check("R1 reset", 4'b1000);
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            enable = VECS[i][10];
            drive(VECS[i][9], VECS[i][8]);
            #1 check($sformatf("R%0d vector %0d", VECS[i][3:0], i), VECS[i][7:4]);
        end

        // R6 / R7: six events, clean cycle, six more, then the seventh trips
        @(negedge clk) begin enable = 1'b1; drive(1'b0, 1'b0); end
        for (int k = 0; k < 6; k++) do_cycle(1'b1, 1'b0);
        #1 check("R7 no trip after six", 4'b1100);
        do_cycle(1'b0, 1'b0);
        for (int k = 0; k < 6; k++) do_cycle(1'b1, 1'b0);
        #1 check("R6 count restarted after clean cycle", 4'b1100);
        do_cycle(1'b1, 1'b0);
        #1 check("R7 R8 trip on seventh", 4'b1011);

        // R9: flag and boundaries have no effect in the latched state
        @(negedge clk) drive(1'b0, 1'b1);
        #1 check("R9 flag ignored in fault", 4'b1011);
        do_cycle(1'b1, 1'b1);
        #1 check("R9 fault held over cycles", 4'b1011);

        // R9: disable clears
        @(negedge clk) begin enable = 1'b0; drive(1'b0, 1'b0); end
        @(negedge clk);
        #1 check("R9 disable clears fault", 4'b1000);
        enable = 1'b1;

        // R5: multiple pulses in one cycle count once
        for (int k = 0; k < 5; k++) do_cycle(1'b1, 1'b0);
        do_cycle(1'b1, 1'b1);
        #1 check("R5 double pulse counted once", 4'b1100);
        do_cycle(1'b1, 1'b0);
        #1 check("R5 R7 trip on seventh cycle", 4'b1011);

        // R9: reset clears at once
        @(negedge clk) begin rst_n = 1'b0; drive(1'b0, 1'b0); end
        #1 check("R9 reset clears fault", 4'b1000);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        #1 check("R2 running after reset release", 4'b0000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule